// File: doc/BRIEF.md
# Quasi-Bidirectional Port Expander with Two-Wire Target Interface

This block is a two-wire serial target that controls 8 or 16 general-purpose pins. It has a single output latch and a single input view and no direction control. A latch bit at one leaves its pin weakly pulled high, so an outside device can pull the pin low and the pin serves as an input. A latch bit at zero actively drives the pin low. A read always returns the levels actually present on the pins. The value last written can never be read back.

A controller writes the latch by sending the target address with the write flag, followed by the data bytes. It reads the pins by sending the address with the read flag and clocking bytes out. No register index byte exists. In the 16-pin build each word travels as two bytes, low pins first. An active-low interrupt output flags any pin whose level has moved away from the snapshot taken at the most recent read.

Each pin leaves the block as a drive-low enable and a pull-up enable. The surrounding pad logic, or a testbench, resolves the pin level from these and from any outside driver.

Top module: `qbx_expander`

## Requirements
- R1: While and after the power-on reset, every latch bit is one: `pin_pull_up` is all ones, `pin_drive_low` is all zeros, `int_n` is high and `sda_oe` is low.
- R2: The block acknowledges only the 7-bit address formed from the upper four bits of `ADDR_BASE` (default 0x20) and `addr_sel` in the three low bits. For any other address it never pulls SDA low and the latch stays unchanged.
- R3: Latch bit k controls pin k. A one sets `pin_pull_up[k]=1` and `pin_drive_low[k]=0`. A zero sets `pin_drive_low[k]=1` and `pin_pull_up[k]=0`. The latch changes only through a completed write word.
- R4: In the 16-pin build, the first data byte of a word is pins 7..0 and the second byte is pins 15..8. The latch updates only when the second byte is received, so a write that ends after one byte leaves the latch unchanged.
- R5: Every data byte of an addressed write is acknowledged. Several words in one transfer each update the latch in turn.
- R6: A read returns live pin levels: a pin reads 0 when it is driven low by its latch or pulled low from outside. Bytes follow the R4 order, and further bytes in the same read repeat the same snapshot.
- R7: `int_n` goes low when the synchronized pin levels differ from the snapshot of the last read. It stays low until the next read, even if the pins return to their earlier levels.
- R8: Acknowledging a read address captures the snapshot and releases `int_n`. A later pin change asserts it again.
- R9: A start condition (SDA falling while SCL is high) begins a new address phase at any point, including in the middle of a write. The block changes `sda_oe` only while SCL is low.
- R10: When the controller does not acknowledge a read byte, the block releases SDA and waits for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Active-low power-on reset, the only way to clear the latch |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, the block pulls SDA low |
| addr_sel | input | 3 | Low three bits of the target address |
| pin_in | input | NUM_PINS | Resolved pin levels |
| pin_drive_low | output | NUM_PINS | Per-pin enable for the strong low driver |
| pin_pull_up | output | NUM_PINS | Per-pin enable for the weak pull-up |
| int_n | output | 1 | Active-low pin-change interrupt |

## Verification
The 16-pin build is driven with write words whose two bytes differ, such as 0x5AA5 and 0x1234. These catch swapped byte order and bits mapped to the wrong pin. Writes are also cut off after one byte or broken by a repeated start, which separates word-level latch update from byte-level update. Reads combine outside pull-downs with latch-driven lows in both bytes, and continue past the word boundary to show that the snapshot repeats. A NACK on the last byte shows that the bus is released. Pin changes applied before and after reads, including a change that reverts, separate the sticky interrupt from a plain level comparison.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK
    } tgt_state_e;
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
    parameter int   WIDTH     = 1,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] s1_q, s1_d, s2_q, s2_d;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= {WIDTH{RESET_VAL}};
            s2_q <= {WIDTH{RESET_VAL}};
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/qbx_i2c_target.sv
module qbx_i2c_target
    import qbx_pkg::*;
#(
    parameter int         NUM_PINS  = 16,
    parameter logic [6:0] ADDR_BASE = 7'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_s,
    input  logic                sda_s,
    input  logic [2:0]          addr_sel,
    input  logic [NUM_PINS-1:0] rd_word,
    output logic                sda_oe,
    output logic                wr_valid,
    output logic                wr_idx,
    output logic [7:0]          wr_byte,
    output logic                rd_go
);
    localparam int         NBYTES  = NUM_PINS / 8;
    localparam logic [3:0] ADDR_HI = ADDR_BASE[6:3];

    typedef struct packed {
        tgt_state_e st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic       oe;
        logic       idx;
        logic       rw;
        logic       mack;
        logic       scl_p;
        logic       sda_p;
        logic       wr_v;
    } regs_t;

    localparam regs_t RST = '{st: ST_IDLE, cnt: 4'd0, sh: 8'd0, oe: 1'b0, idx: 1'b0,
                              rw: 1'b0, mack: 1'b0, scl_p: 1'b1, sda_p: 1'b1, wr_v: 1'b0};

    regs_t q, d;
    logic rise, fall, start_c, stop_c, nidx;
    logic [15:0] wide;
    logic [7:0]  next_byte;

    assign rise    = scl_s & ~q.scl_p;
    assign fall    = ~scl_s & q.scl_p;
    assign start_c = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_c  = scl_s & q.scl_p & ~q.sda_p & sda_s;
    assign wide    = 16'(rd_word);
    assign nidx    = (NBYTES == 2) ? ~q.idx : 1'b0;
    assign next_byte = nidx ? wide[15:8] : wide[7:0];

    always_comb begin
        d       = q;
        d.scl_p = scl_s;
        d.sda_p = sda_s;
        d.wr_v  = 1'b0;
        rd_go   = 1'b0;
        if (start_c) begin
            d.st  = ST_ADDR;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else if (stop_c) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == 4'd8) begin
                        d.cnt = 4'd0;
                        if (q.sh[7:1] == {ADDR_HI, addr_sel}) begin
                            d.st = ST_AACK;
                            d.oe = 1'b1;
                            d.rw = q.sh[0];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (fall) begin
                        d.idx = 1'b0;
                        if (q.rw) begin
                            rd_go = 1'b1;
                            d.sh  = wide[7:0];
                            d.oe  = ~wide[7];
                            d.st  = ST_RDAT;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_WDAT;
                        end
                    end
                end
                ST_WDAT: begin
                    if (rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == 4'd8) begin
                        d.cnt  = 4'd0;
                        d.oe   = 1'b1;
                        d.wr_v = 1'b1;
                        d.st   = ST_WACK;
                    end
                end
                ST_WACK: begin
                    if (fall) begin
                        d.oe  = 1'b0;
                        d.idx = nidx;
                        d.st  = ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall) begin
                        if (q.cnt == 4'd8) begin
                            d.cnt = 4'd0;
                            d.oe  = 1'b0;
                            d.st  = ST_RACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (rise) begin
                        d.mack = ~sda_s;
                    end else if (fall) begin
                        if (q.mack) begin
                            d.idx = nidx;
                            d.sh  = next_byte;
                            d.oe  = ~next_byte[7];
                            d.st  = ST_RDAT;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign sda_oe   = q.oe;
    assign wr_valid = q.wr_v;
    assign wr_idx   = q.idx;
    assign wr_byte  = q.sh;
endmodule

// File: rtl/qbx_port.sv
module qbx_port #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                wr_valid,
    input  logic                wr_idx,
    input  logic [7:0]          wr_byte,
    input  logic                rd_go,
    output logic [NUM_PINS-1:0] rd_word,
    output logic [NUM_PINS-1:0] pin_drive_low,
    output logic [NUM_PINS-1:0] pin_pull_up,
    output logic                int_n
);
    localparam int NBYTES = NUM_PINS / 8;

    typedef struct packed {
        logic [NUM_PINS-1:0] latch;
        logic [NUM_PINS-1:0] snap;
        logic [NUM_PINS-1:0] refv;
        logic [7:0]          stage;
        logic                pend;
    } regs_t;

    regs_t q, d;
    logic [NUM_PINS-1:0] pins_s;
    logic [NUM_PINS-1:0] wr_word;
    logic                word_done;

    qbx_sync #(.WIDTH(NUM_PINS), .RESET_VAL(1'b1)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pins_s)
    );

    generate
        if (NBYTES == 1) begin : g_byte_word
            assign wr_word   = wr_byte;
            assign word_done = wr_valid;
        end else begin : g_pair_word
            assign wr_word   = {wr_byte, q.stage};
            assign word_done = wr_valid & wr_idx;
        end
    endgenerate

    always_comb begin
        d = q;
        if (wr_valid && !wr_idx) d.stage = wr_byte;
        if (word_done)           d.latch = wr_word;
        if (rd_go) begin
            d.snap = pins_s;
            d.refv = pins_s;
            d.pend = 1'b0;
        end else if (pins_s != q.refv) begin
            d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.latch <= '1;
            q.snap  <= '1;
            q.refv  <= '1;
            q.stage <= '0;
            q.pend  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_word       = rd_go ? pins_s : q.snap;
    assign pin_drive_low = ~q.latch;
    assign pin_pull_up   = q.latch;
    assign int_n         = ~q.pend;
endmodule

// File: rtl/qbx_expander.sv
module qbx_expander #(
    parameter int         NUM_PINS  = 16,
    parameter logic [6:0] ADDR_BASE = 7'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_oe,
    input  logic [2:0]          addr_sel,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_drive_low,
    output logic [NUM_PINS-1:0] pin_pull_up,
    output logic                int_n
);
    logic                scl_s, sda_s;
    logic                wr_valid, wr_idx, rd_go;
    logic [7:0]          wr_byte;
    logic [NUM_PINS-1:0] rd_word;

    qbx_sync #(.WIDTH(2), .RESET_VAL(1'b1)) u_bus_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout ({scl_s, sda_s})
    );

    qbx_i2c_target #(.NUM_PINS(NUM_PINS), .ADDR_BASE(ADDR_BASE)) u_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .addr_sel(addr_sel),
        .rd_word (rd_word),
        .sda_oe  (sda_oe),
        .wr_valid(wr_valid),
        .wr_idx  (wr_idx),
        .wr_byte (wr_byte),
        .rd_go   (rd_go)
    );

    qbx_port #(.NUM_PINS(NUM_PINS)) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_in       (pin_in),
        .wr_valid     (wr_valid),
        .wr_idx       (wr_idx),
        .wr_byte      (wr_byte),
        .rd_go        (rd_go),
        .rd_word      (rd_word),
        .pin_drive_low(pin_drive_low),
        .pin_pull_up  (pin_pull_up),
        .int_n        (int_n)
    );
endmodule

// File: rtl/qbx_expander_chk.sv
module qbx_expander_chk #(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_in,
    input logic                sda_oe,
    input logic                int_n,
    input logic [NUM_PINS-1:0] pin_pull_up,
    input logic                wr_valid,
    input logic                wr_idx,
    input logic                rd_go
);
    // R1: latch comes out of reset at all ones
    assert_reset_ones_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pin_pull_up == {NUM_PINS{1'b1}}));

    // R9: SDA drive only begins or ends while SCL is low
    assert_drive_in_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in);
    assert_release_in_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_in);

    // R3: the latch moves only right after a received write byte
    assert_latch_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_pull_up) |-> $past(wr_valid));

    // R4: the first byte of a two-byte word never reaches the pins
    generate
        if (NUM_PINS == 16) begin : g_pair
            assert_first_byte_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && !wr_idx) |=> $stable(pin_pull_up));
        end
    endgenerate

    // R7: a pending change stays flagged until a read
    assert_int_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && !rd_go) |=> !int_n);

    // R8: a read capture releases the interrupt
    assert_int_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> int_n);
endmodule

bind qbx_expander qbx_expander_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_oe     (sda_oe),
    .int_n      (int_n),
    .pin_pull_up(pin_pull_up),
    .wr_valid   (wr_valid),
    .wr_idx     (wr_idx),
    .rd_go      (rd_go)
);

// File: tb/tb_qbx_expander.sv
module tb_qbx_expander;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic [2:0]    addr_sel = 3'd0;
    logic [NP-1:0] ext_low = '0;
    logic          sda_line;
    logic [NP-1:0] pin_lvl, drv_low, pull_up;
    logic          sda_oe, int_n;
    logic [NP-1:0] latch_m = '1;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign pin_lvl  = ~drv_low & ~ext_low;

    qbx_expander #(.NUM_PINS(NP), .ADDR_BASE(7'h20)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda_line),
        .sda_oe       (sda_oe),
        .addr_sel     (addr_sel),
        .pin_in       (pin_lvl),
        .pin_drive_low(drv_low),
        .pin_pull_up  (pull_up),
        .int_n        (int_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hold(5);
        scl = 1'b1;   hold(10);
        sda_m = 1'b0; hold(10);
        scl = 1'b0;   hold(5);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hold(5);
        scl = 1'b1;   hold(10);
        sda_m = 1'b1; hold(10);
    endtask

    task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(5);
            scl = 1'b1;   hold(10);
            scl = 1'b0;   hold(5);
        end
        sda_m = 1'b1; hold(5);
        scl = 1'b1;   hold(5);
        ack = ~sda_line;
        hold(5);
        scl = 1'b0;   hold(5);
    endtask

    task automatic i2c_rbyte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(5);
            scl = 1'b1; hold(5);
            b[i] = sda_line;
            hold(5);
            scl = 1'b0; hold(5);
        end
        sda_m = ~mack; hold(5);
        scl = 1'b1;    hold(10);
        scl = 1'b0;    hold(5);
        sda_m = 1'b1;
    endtask

    task automatic write_word(input logic [15:0] w);
        logic a;
        i2c_start();
        i2c_wbyte({7'h20, 1'b0}, a);
        i2c_wbyte(w[7:0], a);
        i2c_wbyte(w[15:8], a);
        i2c_stop();
        latch_m = w;
        hold(5);
    endtask

    task automatic t_reset();
        check("R1 pull_up", 32'(pull_up), 32'hFFFF);
        check("R1 drive_low", 32'(drv_low), 32'h0000);
        check("R1 int_n", 32'(int_n), 32'h1);
        check("R1 sda_oe", 32'(sda_oe), 32'h0);
    endtask

    task automatic t_write();
        logic a;
        i2c_start();
        i2c_wbyte({7'h20, 1'b0}, a); check("R2 address ack", 32'(a), 32'h1);
        i2c_wbyte(8'hA5, a);         check("R5 byte0 ack", 32'(a), 32'h1);
        i2c_wbyte(8'h5A, a);         check("R5 byte1 ack", 32'(a), 32'h1);
        i2c_stop();
        latch_m = 16'h5AA5;
        check("R3 R4 pull_up order", 32'(pull_up), 32'h5AA5);
        check("R3 drive_low", 32'(drv_low), 32'hA55A);
        hold(10);
        check("R7 int after pins drop", 32'(int_n), 32'h0);
    endtask

    task automatic t_partial();
        logic a;
        i2c_start();
        i2c_wbyte({7'h20, 1'b0}, a);
        i2c_wbyte(8'h00, a);
        i2c_stop();
        check("R4 half word ignored", 32'(pull_up), 32'(latch_m));
    endtask

    task automatic t_address();
        logic a;
        i2c_start();
        i2c_wbyte({7'h21, 1'b0}, a); check("R2 wrong address nack", 32'(a), 32'h0);
        i2c_wbyte(8'h00, a);         check("R2 no data ack", 32'(a), 32'h0);
        i2c_wbyte(8'h00, a);
        i2c_stop();
        check("R2 latch untouched", 32'(pull_up), 32'(latch_m));
        addr_sel = 3'd1;
        i2c_start();
        i2c_wbyte({7'h21, 1'b0}, a); check("R2 selected address ack", 32'(a), 32'h1);
        i2c_wbyte(8'hFF, a);
        i2c_wbyte(8'hFF, a);
        i2c_stop();
        latch_m = 16'hFFFF;
        check("R2 write at selected address", 32'(pull_up), 32'hFFFF);
        addr_sel = 3'd0;
        hold(5);
    endtask

    task automatic t_multi();
        logic a;
        i2c_start();
        i2c_wbyte({7'h20, 1'b0}, a);
        i2c_wbyte(8'h34, a);
        i2c_wbyte(8'h12, a);
        check("R5 first word applied", 32'(pull_up), 32'h1234);
        i2c_wbyte(8'hFF, a);
        i2c_wbyte(8'hFF, a); check("R5 fourth byte ack", 32'(a), 32'h1);
        i2c_stop();
        latch_m = 16'hFFFF;
        check("R5 second word applied", 32'(pull_up), 32'hFFFF);
    endtask

    task automatic t_restart();
        logic a;
        i2c_start();
        i2c_wbyte({7'h20, 1'b0}, a);
        i2c_wbyte(8'h00, a);
        i2c_start();
        i2c_wbyte({7'h20, 1'b0}, a); check("R9 restart address ack", 32'(a), 32'h1);
        i2c_wbyte(8'hFF, a);
        i2c_wbyte(8'h7F, a);
        i2c_stop();
        latch_m = 16'h7FFF;
        check("R9 restart realigns word", 32'(pull_up), 32'h7FFF);
        write_word(16'hFFFF);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] b;
        logic [15:0] lvl;
        ext_low = 16'h00F0;
        hold(10);
        lvl = latch_m & ~ext_low;
        i2c_start();
        i2c_wbyte({7'h20, 1'b1}, a); check("R2 read address ack", 32'(a), 32'h1);
        check("R8 int released on read", 32'(int_n), 32'h1);
        i2c_rbyte(1'b1, b); check("R6 read byte0", 32'(b), 32'(lvl[7:0]));
        i2c_rbyte(1'b1, b); check("R6 read byte1", 32'(b), 32'(lvl[15:8]));
        i2c_rbyte(1'b1, b); check("R6 repeat byte0", 32'(b), 32'(lvl[7:0]));
        i2c_rbyte(1'b0, b); check("R6 repeat byte1", 32'(b), 32'(lvl[15:8]));
        check("R10 released after nack", 32'(sda_oe), 32'h0);
        i2c_stop();
        write_word(16'hFFFE);
        ext_low = 16'h0100;
        hold(10);
        lvl = latch_m & ~ext_low;
        i2c_start();
        i2c_wbyte({7'h20, 1'b1}, a);
        i2c_rbyte(1'b1, b); check("R6 driven low reads 0", 32'(b), 32'(lvl[7:0]));
        i2c_rbyte(1'b0, b); check("R6 pulled low reads 0", 32'(b), 32'(lvl[15:8]));
        i2c_stop();
        check("R10 idle after read", 32'(sda_oe), 32'h0);
    endtask

    task automatic t_int();
        logic a;
        logic [7:0] b;
        check("R8 int high after read", 32'(int_n), 32'h1);
        ext_low = ext_low | 16'h0008;
        hold(10);
        check("R7 change asserts int", 32'(int_n), 32'h0);
        ext_low = ext_low & ~16'h0008;
        hold(10);
        check("R7 int stays after revert", 32'(int_n), 32'h0);
        i2c_start();
        i2c_wbyte({7'h20, 1'b1}, a);
        check("R8 read clears int", 32'(int_n), 32'h1);
        i2c_rbyte(1'b0, b);
        i2c_stop();
        ext_low = ext_low | 16'h8000;
        hold(10);
        check("R8 new change reasserts", 32'(int_n), 32'h0);
    endtask

    initial begin
        hold(4);
        t_reset();
        rst_n = 1'b1;
        hold(5);
        t_reset();
        t_write();
        t_partial();
        t_address();
        t_multi();
        t_restart();
        t_read();
        t_int();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule